// File: doc/BRIEF.md
# SMBus Host Register File Stub

This block presents the sixteen-byte I/O window of an SMBus host controller as a bank of registers, without driving any serial bus. Software can program the command, address and data registers, fill or drain a 32-byte block buffer, and launch or abort a transfer. A launch finishes at once with a device error. An abort finishes at once with a failure report. Both raise the interrupt flag in host status, so driver code that polls status or waits for an interrupt always sees a completion.

Each access is one cycle long. `req_en` qualifies `req_off`, `req_size`, `req_wr` and `req_wdata`. A read returns its data one cycle later on `rd_data` with `rd_valid` high. If the offset and size do not fit, `rd_unused` is raised instead. The interrupt enable bit and the four host-status event bits are brought out raw, so that a neighbouring interrupt router can form the request line.

Top module: `smb_host_stub`

## Requirements
- R1: A read request (`req_en`=1, `req_wr`=0) gives `rd_valid`=1 in the next cycle with that register's value, zero-extended, on `rd_data`. A cycle with no read request gives `rd_valid`=0 in the next cycle. The offsets are: 0x0 host status, 0x1 slave status, 0x2 host control, 0x3 command, 0x4 address, 0x5 data 0, 0x6 data 1, 0x7 block data, 0x8 slave control, 0x9 shadow command, 0xA slave event, 0xC slave data.
- R2: Offsets 0x0–0x9 accept only `req_size`=1 (one byte). Offsets 0xA and 0xC accept only `req_size`=2 (two bytes). Offsets 0xB, 0xD, 0xE and 0xF are unmapped. A read that breaks these rules returns `rd_unused`=1 with `rd_data` all ones. No access that breaks them, read or write, changes any state, including the block index.
- R3: In host status, bit 0 (busy) reads 0 and ignores writes, and bits 7:5 read 0. Bits 1 (interrupt), 2 (device error), 3 (bus error) and 4 (failed) are cleared by writing 1 to them.
- R4: A write to host control stores only bits 4:0: bit 0 interrupt enable, bit 1 kill, bits 4:2 protocol. Bits 7:5, including the start bit 6, always read back 0.
- R5: A host-control write with bit 6 set sets host-status bits 2 and 1.
- R6: A host-control write with bit 1 set sets host-status bits 4 and 1. With bits 6 and 1 both set in one write, bits 4, 2 and 1 are all set by that single write.
- R7: Each legal read or write at offset 0x7 accesses buffer entry [index] and then increments the index. The index wraps from 31 to 0.
- R8: A legal read of host control resets the block index to 0.
- R9: Slave control stores only bits 3:0. In slave status, bits 5:2 are write-1-to-clear and the rest ignore writes. Shadow command and slave data are read-only and ignore writes.
- R10: Command, address, data 0 and data 1 are 8-bit read/write registers. Slave event is a 16-bit read/write register.
- R11: Reset clears every register, all 32 buffer bytes and the block index, and holds `rd_valid` low.
- R12: `irq_enable` equals host-control bit 0. `irq_flags[3:0]` equals host-status bits 4:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_en | input | 1 | Access strobe for this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_off | input | 4 | Byte offset inside the window |
| req_size | input | 2 | Access size: 1 = one byte, 2 = two bytes |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 16 | Read response data |
| rd_unused | output | 1 | Read was rejected (bad offset or size) |
| irq_enable | output | 1 | Host interrupt enable bit |
| irq_flags | output | 4 | Host-status event bits 4:1 |

## Verification
The one place where two functions land in the same cycle is a single host-control write that carries both start and kill. That one write must OR the device-error and failed events into status on top of the shared interrupt bit, with neither update masking the other. The bench provokes this with a write of 0x43. It then judges the outcome in two ways: at once on `irq_flags`, which must read 4'b1011, and by a status read, which must return 0x16. A second pairing checks that this write also stores its kill and enable bits in control while dropping start, and the bench confirms this by reading control back as 0x03.

// File: rtl/smb_stub_pkg.sv
package smb_stub_pkg;

   localparam int OFF_W   = 4;
   localparam int NUM_SEL = 12;

   // one-hot select positions
   localparam int SEL_HST_STS = 0;
   localparam int SEL_SLV_STS = 1;
   localparam int SEL_HST_CTL = 2;
   localparam int SEL_CMD     = 3;
   localparam int SEL_ADDR    = 4;
   localparam int SEL_DAT0    = 5;
   localparam int SEL_DAT1    = 6;
   localparam int SEL_BLK     = 7;
   localparam int SEL_SLV_CTL = 8;
   localparam int SEL_SHDW    = 9;
   localparam int SEL_SLV_EVT = 10;
   localparam int SEL_SLV_DAT = 11;

   localparam logic [1:0] SZ_ONE = 2'd1;
   localparam logic [1:0] SZ_TWO = 2'd2;

   localparam int CTL_INTEN_BIT = 0;
   localparam int CTL_KILL_BIT  = 1;
   localparam int CTL_START_BIT = 6;

   localparam logic [7:0] STS_W1C_MASK  = 8'h1E;
   localparam logic [7:0] STS_ON_START  = 8'h06;
   localparam logic [7:0] STS_ON_KILL   = 8'h12;
   localparam logic [7:0] CTL_KEEP_MASK = 8'h1F;
   localparam logic [7:0] SLV_W1C_MASK  = 8'h3C;
   localparam logic [7:0] SLV_CTL_KEEP  = 8'h0F;

   typedef struct packed {
      logic [7:0]  hst_sts;
      logic [7:0]  slv_sts;
      logic [7:0]  hst_ctl;
      logic [7:0]  cmd;
      logic [7:0]  addr;
      logic [7:0]  dat0;
      logic [7:0]  dat1;
      logic [7:0]  slv_ctl;
      logic [7:0]  shdw;
      logic [15:0] slv_evt;
      logic [15:0] slv_dat;
   } smb_regs_t;

   function automatic logic [OFF_W-1:0] sel_off(input int i);
      case (i)
         SEL_HST_STS: return 4'h0;
         SEL_SLV_STS: return 4'h1;
         SEL_HST_CTL: return 4'h2;
         SEL_CMD:     return 4'h3;
         SEL_ADDR:    return 4'h4;
         SEL_DAT0:    return 4'h5;
         SEL_DAT1:    return 4'h6;
         SEL_BLK:     return 4'h7;
         SEL_SLV_CTL: return 4'h8;
         SEL_SHDW:    return 4'h9;
         SEL_SLV_EVT: return 4'hA;
         default:     return 4'hC;
      endcase
   endfunction

   function automatic logic sel_wide(input int i);
      return (i == SEL_SLV_EVT) || (i == SEL_SLV_DAT);
   endfunction

endpackage

// File: rtl/smb_acc_decode.sv
module smb_acc_decode
   import smb_stub_pkg::*;
(
   input  logic                req_en,
   input  logic                req_wr,
   input  logic [OFF_W-1:0]    req_off,
   input  logic [1:0]          req_size,
   output logic [NUM_SEL-1:0]  sel,
   output logic                acc_ok,
   output logic                rd_go,
   output logic                wr_go
);

   logic [NUM_SEL-1:0] hit;
   logic [NUM_SEL-1:0] fit;

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_slot
      assign hit[g] = (req_off == sel_off(g));
      if (sel_wide(g)) begin : g_wide
         assign fit[g] = (req_size == SZ_TWO);
      end else begin : g_narrow
         assign fit[g] = (req_size == SZ_ONE);
      end
   end

   assign sel    = hit;
   assign acc_ok = req_en & |(hit & fit);
   assign rd_go  = acc_ok & ~req_wr;
   assign wr_go  = acc_ok &  req_wr;

endmodule

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
   parameter int DEPTH = 32,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          blk_rd,
   input  logic          blk_wr,
   input  logic          idx_clr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("smb_blk_buf: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("smb_blk_buf: DW must be positive");
   end

   logic [DW-1:0]    mem [DEPTH];
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] idx_inc;

   // power-of-two depth wraps by truncation, other depths by compare
   if (DEPTH == (1 << IDX_W)) begin : g_wrap_pow2
      assign idx_inc = idx + 1'b1;
   end else begin : g_wrap_cmp
      assign idx_inc = (idx == LAST) ? '0 : idx + 1'b1;
   end

   assign rdata = mem[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (blk_wr) mem[idx] <= wdata;
         if (idx_clr)                 idx <= '0;
         else if (blk_rd || blk_wr)   idx <= idx_inc;
      end
   end

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_rd || blk_wr) && !idx_clr && idx != LAST |=> idx == IDX_W'($past(idx) + 1'b1)); // R7
   AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_rd || blk_wr) && !idx_clr && idx == LAST |=> idx == '0); // R7
   AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      idx_clr |=> idx == '0); // R8
   AST_BLK_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      blk_wr |=> mem[$past(idx)] == $past(wdata)); // R7

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
   import smb_stub_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SEL-1:0] sel,
   input  logic               wr_go,
   input  logic [15:0]        wdata,
   output smb_regs_t          regs
);

   smb_regs_t  nx;
   logic [7:0] wb;

   assign wb = wdata[7:0];

   always_comb begin
      nx = regs;
      if (wr_go) begin
         if (sel[SEL_HST_STS]) nx.hst_sts = regs.hst_sts & ~(wb & STS_W1C_MASK);
         if (sel[SEL_SLV_STS]) nx.slv_sts = regs.slv_sts & ~(wb & SLV_W1C_MASK);
         if (sel[SEL_HST_CTL]) begin
            nx.hst_ctl = wb & CTL_KEEP_MASK;
            if (wb[CTL_START_BIT]) nx.hst_sts = nx.hst_sts | STS_ON_START;
            if (wb[CTL_KILL_BIT])  nx.hst_sts = nx.hst_sts | STS_ON_KILL;
         end
         if (sel[SEL_CMD])     nx.cmd     = wb;
         if (sel[SEL_ADDR])    nx.addr    = wb;
         if (sel[SEL_DAT0])    nx.dat0    = wb;
         if (sel[SEL_DAT1])    nx.dat1    = wb;
         if (sel[SEL_SLV_CTL]) nx.slv_ctl = wb & SLV_CTL_KEEP;
         if (sel[SEL_SLV_EVT]) nx.slv_evt = wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs <= '0;
      else        regs <= nx;
   end

   AST_START_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go && sel[SEL_HST_CTL] && wdata[CTL_START_BIT] |=> regs.hst_sts[2] && regs.hst_sts[1]); // R5
   AST_KILL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go && sel[SEL_HST_CTL] && wdata[CTL_KILL_BIT] |=> regs.hst_sts[4] && regs.hst_sts[1]); // R6
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go && sel[SEL_HST_STS] |=> (regs.hst_sts[4:1] & $past(wdata[4:1])) == 4'b0); // R3
   AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go && sel[SEL_HST_CTL] |=> regs.hst_ctl[7:5] == 3'b0); // R4

endmodule

// File: rtl/smb_host_stub.sv
module smb_host_stub
   import smb_stub_pkg::*;
#(
   parameter int               BUF_DEPTH   = 32,
   parameter int               BUS_W       = 16,
   parameter logic [BUS_W-1:0] UNUSED_FILL = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_en,
   input  logic               req_wr,
   input  logic [OFF_W-1:0]   req_off,
   input  logic [1:0]         req_size,
   input  logic [BUS_W-1:0]   req_wdata,
   output logic               rd_valid,
   output logic [BUS_W-1:0]   rd_data,
   output logic               rd_unused,
   output logic               irq_enable,
   output logic [3:0]         irq_flags
);

   if (BUS_W < 16) begin : g_bad_bus
      $error("smb_host_stub: BUS_W must be at least 16");
   end

   logic [NUM_SEL-1:0] sel;
   logic               acc_ok, rd_go, wr_go;
   smb_regs_t          regs;
   logic [7:0]         blk_rdata;
   logic [BUS_W-1:0]   rd_next;
   logic               rd_req;
   logic               unused_hi;

   assign unused_hi = ^req_wdata;

   smb_acc_decode u_dec (
      .req_en   (req_en),
      .req_wr   (req_wr),
      .req_off  (req_off),
      .req_size (req_size),
      .sel      (sel),
      .acc_ok   (acc_ok),
      .rd_go    (rd_go),
      .wr_go    (wr_go)
   );

   smb_host_regs u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel),
      .wr_go (wr_go),
      .wdata (req_wdata[15:0]),
      .regs  (regs)
   );

   smb_blk_buf #(.DEPTH(BUF_DEPTH), .DW(8)) u_blk (
      .clk     (clk),
      .rst_n   (rst_n),
      .blk_rd  (rd_go & sel[SEL_BLK]),
      .blk_wr  (wr_go & sel[SEL_BLK]),
      .idx_clr (rd_go & sel[SEL_HST_CTL]),
      .wdata   (req_wdata[7:0]),
      .rdata   (blk_rdata)
   );

   always_comb begin
      rd_next = '0;
      if (sel[SEL_HST_STS]) rd_next = BUS_W'(regs.hst_sts);
      if (sel[SEL_SLV_STS]) rd_next = BUS_W'(regs.slv_sts);
      if (sel[SEL_HST_CTL]) rd_next = BUS_W'(regs.hst_ctl);
      if (sel[SEL_CMD])     rd_next = BUS_W'(regs.cmd);
      if (sel[SEL_ADDR])    rd_next = BUS_W'(regs.addr);
      if (sel[SEL_DAT0])    rd_next = BUS_W'(regs.dat0);
      if (sel[SEL_DAT1])    rd_next = BUS_W'(regs.dat1);
      if (sel[SEL_BLK])     rd_next = BUS_W'(blk_rdata);
      if (sel[SEL_SLV_CTL]) rd_next = BUS_W'(regs.slv_ctl);
      if (sel[SEL_SHDW])    rd_next = BUS_W'(regs.shdw);
      if (sel[SEL_SLV_EVT]) rd_next = BUS_W'(regs.slv_evt);
      if (sel[SEL_SLV_DAT]) rd_next = BUS_W'(regs.slv_dat);
   end

   assign rd_req = req_en & ~req_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         rd_unused <= 1'b0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) begin
            rd_unused <= ~acc_ok;
            rd_data   <= acc_ok ? rd_next : UNUSED_FILL;
         end
      end
   end

   assign irq_enable = regs.hst_ctl[CTL_INTEN_BIT];
   assign irq_flags  = regs.hst_sts[4:1];

   AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid); // R1
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid); // R1
   AST_BAD_READ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !acc_ok |=> rd_unused && rd_data == UNUSED_FILL); // R2
   AST_BAD_ACCESS_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      req_en && !acc_ok |=> $stable(irq_flags) && $stable(irq_enable)); // R2

endmodule

// File: tb/sim_smb_host_stub.sv
`timescale 1ns/1ps
module sim_smb_host_stub;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_en = 1'b0;
   logic        req_wr = 1'b0;
   logic [3:0]  req_off = '0;
   logic [1:0]  req_size = '0;
   logic [15:0] req_wdata = '0;
   logic        rd_valid, rd_unused, irq_enable;
   logic [15:0] rd_data;
   logic [3:0]  irq_flags;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [16:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   smb_host_stub u0 (
      .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr),
      .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_unused(rd_unused),
      .irq_enable(irq_enable), .irq_flags(irq_flags)
   );

   task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] off, input logic [1:0] sz, input logic [15:0] d);
      req_en = 1'b1; req_wr = 1'b1; req_off = off; req_size = sz; req_wdata = d;
      @(negedge clk);
      req_en = 1'b0; req_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] off, input logic [1:0] sz,
                     input logic [15:0] exp, input logic exp_un, input string tag);
      exp_q.push_back({exp_un, exp});
      tag_q.push_back(tag);
      req_en = 1'b1; req_wr = 1'b0; req_off = off; req_size = sz; req_wdata = '0;
      @(negedge clk);
      req_en = 1'b0;
   endtask

   // monitor: pops expected read results as the design answers
   always @(negedge clk) begin
      if (rd_valid) begin
         if (exp_q.size() == 0) begin
            n_run++; n_fail++;
            $display("FAIL R1: unexpected response got %h expected none", rd_data);
         end else begin
            chk(tag_q.pop_front(), {rd_unused, rd_data}, exp_q.pop_front());
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 rd_valid in reset", {16'h0, rd_valid}, 17'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 irq_flags after reset", {13'h0, irq_flags}, 17'h0);
      chk("R12 irq_enable after reset", {16'h0, irq_enable}, 17'h0);

      // R11 every register zero after reset
      rd(4'h0, 2'd1, 16'h0, 1'b0, "R11 host status");
      rd(4'h1, 2'd1, 16'h0, 1'b0, "R11 slave status");
      rd(4'h2, 2'd1, 16'h0, 1'b0, "R11 host control");
      rd(4'h3, 2'd1, 16'h0, 1'b0, "R11 command");
      rd(4'h4, 2'd1, 16'h0, 1'b0, "R11 address");
      rd(4'h5, 2'd1, 16'h0, 1'b0, "R11 data0");
      rd(4'h6, 2'd1, 16'h0, 1'b0, "R11 data1");
      rd(4'h7, 2'd1, 16'h0, 1'b0, "R11 block");
      rd(4'h8, 2'd1, 16'h0, 1'b0, "R11 slave control");
      rd(4'h9, 2'd1, 16'h0, 1'b0, "R11 shadow");
      rd(4'hA, 2'd2, 16'h0, 1'b0, "R11 slave event");
      rd(4'hC, 2'd2, 16'h0, 1'b0, "R11 slave data");

      // R10 plain registers
      wr(4'h3, 2'd1, 16'h00A5);
      wr(4'h4, 2'd1, 16'h003C);
      wr(4'h5, 2'd1, 16'h0011);
      wr(4'h6, 2'd1, 16'h00EE);
      wr(4'hA, 2'd2, 16'hBEEF);
      rd(4'h3, 2'd1, 16'h00A5, 1'b0, "R10 command");
      rd(4'h4, 2'd1, 16'h003C, 1'b0, "R10 address");
      rd(4'h5, 2'd1, 16'h0011, 1'b0, "R10 data0");
      rd(4'h6, 2'd1, 16'h00EE, 1'b0, "R10 data1");
      rd(4'hA, 2'd2, 16'hBEEF, 1'b0, "R10 slave event");

      // R9 slave side masks and read-only registers
      wr(4'h8, 2'd1, 16'h00FF);
      wr(4'h9, 2'd1, 16'h0077);
      wr(4'hC, 2'd2, 16'h1234);
      wr(4'h1, 2'd1, 16'h00FF);
      rd(4'h8, 2'd1, 16'h000F, 1'b0, "R9 slave control mask");
      rd(4'h9, 2'd1, 16'h0000, 1'b0, "R9 shadow read-only");
      rd(4'hC, 2'd2, 16'h0000, 1'b0, "R9 slave data read-only");
      rd(4'h1, 2'd1, 16'h0000, 1'b0, "R9 slave status");

      // R4 control storage, no events
      wr(4'h2, 2'd1, 16'h001D);
      chk("R12 irq_enable set", {16'h0, irq_enable}, 17'h1);
      chk("R4 no event on plain control write", {13'h0, irq_flags}, 17'h0);
      rd(4'h2, 2'd1, 16'h001D, 1'b0, "R4 control readback");

      // R5 start
      wr(4'h2, 2'd1, 16'h00E0);
      chk("R5 flags after start", {13'h0, irq_flags}, 17'h3);
      chk("R12 irq_enable cleared", {16'h0, irq_enable}, 17'h0);
      rd(4'h2, 2'd1, 16'h0000, 1'b0, "R4 start bit not stored");
      rd(4'h0, 2'd1, 16'h0006, 1'b0, "R5 status after start");

      // R3 write-1-to-clear
      wr(4'h0, 2'd1, 16'h0004);
      rd(4'h0, 2'd1, 16'h0002, 1'b0, "R3 clear device error");
      wr(4'h0, 2'd1, 16'h00E1);
      rd(4'h0, 2'd1, 16'h0002, 1'b0, "R3 busy and reserved ignore writes");
      wr(4'h0, 2'd1, 16'h0002);
      rd(4'h0, 2'd1, 16'h0000, 1'b0, "R3 clear interrupt");

      // R6 kill, then start and kill together
      wr(4'h2, 2'd1, 16'h0002);
      rd(4'h0, 2'd1, 16'h0012, 1'b0, "R6 status after kill");
      rd(4'h2, 2'd1, 16'h0002, 1'b0, "R4 kill bit stored");
      wr(4'h0, 2'd1, 16'h00FF);
      wr(4'h2, 2'd1, 16'h0043);
      chk("R6 flags after start plus kill", {13'h0, irq_flags}, 17'hB);
      chk("R12 irq_enable with start plus kill", {16'h0, irq_enable}, 17'h1);
      rd(4'h0, 2'd1, 16'h0016, 1'b0, "R6 status after start plus kill");
      rd(4'h2, 2'd1, 16'h0003, 1'b0, "R6 control after start plus kill");
      wr(4'h0, 2'd1, 16'h001E);
      chk("R3 flags cleared", {13'h0, irq_flags}, 17'h0);

      // R2 size and offset rules
      rd(4'h0, 2'd2, 16'hFFFF, 1'b1, "R2 wide read of byte register");
      rd(4'hA, 2'd1, 16'hFFFF, 1'b1, "R2 byte read of wide register");
      rd(4'hB, 2'd1, 16'hFFFF, 1'b1, "R2 unmapped 0xB");
      rd(4'hF, 2'd2, 16'hFFFF, 1'b1, "R2 unmapped 0xF");
      wr(4'h3, 2'd2, 16'h0055);
      rd(4'h3, 2'd1, 16'h00A5, 1'b0, "R2 bad-size write ignored");
      wr(4'h2, 2'd2, 16'h0043);
      chk("R2 bad-size control write no event", {13'h0, irq_flags}, 17'h0);
      rd(4'h0, 2'd1, 16'h0000, 1'b0, "R2 status after bad-size control write");

      // R7 R8 block buffer
      rd(4'h2, 2'd1, 16'h0003, 1'b0, "R8 control read resets index");
      for (int i = 0; i < 32; i++) wr(4'h7, 2'd1, 16'(8'h40 + i));
      wr(4'h7, 2'd1, 16'h00C0);
      rd(4'h2, 2'd1, 16'h0003, 1'b0, "R8 control read");
      rd(4'h7, 2'd1, 16'h00C0, 1'b0, "R7 wrapped write landed at 0");
      for (int i = 1; i < 32; i++) rd(4'h7, 2'd1, 16'(8'h40 + i), 1'b0, "R7 block sequence");
      rd(4'h7, 2'd1, 16'h00C0, 1'b0, "R7 read index wraps");
      wr(4'h7, 2'd2, 16'h0099);
      rd(4'h7, 2'd2, 16'hFFFF, 1'b1, "R2 bad-size block read");
      rd(4'h7, 2'd1, 16'h0041, 1'b0, "R2 bad block access keeps index");
      rd(4'h7, 2'd1, 16'h0042, 1'b0, "R7 next entry");
      rd(4'h2, 2'd1, 16'h0003, 1'b0, "R8 control read");
      rd(4'h7, 2'd1, 16'h00C0, 1'b0, "R8 index back at 0");

      // R11 reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 rd_valid during reset", {16'h0, rd_valid}, 17'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 flags after second reset", {12'h0, irq_enable, irq_flags}, 17'h0);
      rd(4'h7, 2'd1, 16'h0000, 1'b0, "R11 buffer cleared");
      rd(4'h7, 2'd1, 16'h0000, 1'b0, "R11 buffer cleared entry 1");
      rd(4'h3, 2'd1, 16'h0000, 1'b0, "R11 command cleared");
      rd(4'hA, 2'd2, 16'h0000, 1'b0, "R11 slave event cleared");
      rd(4'h2, 2'd1, 16'h0000, 1'b0, "R11 control cleared");

      repeat (2) @(negedge clk);
      chk("R1 all responses seen", {16'h0, exp_q.size() != 0}, 17'h0);
      finish_run();
   end

endmodule